// File: doc/BRIEF.md
# Lockable Watchdog Timer with Standby Control

This block is a watchdog that counts ticks taken from one of three prescaler outputs: a main-clock timebase, a watch prescaler and a sub-oscillator timer. Software starts it, and later services it, by writing a fixed key value into a 4-bit control field. Once started it cannot be stopped; only a system reset returns it to idle. If the counter passes its terminal value, the block sends a one-cycle reset request to the system reset controller and sets a sticky flag that records the event.

The 3-bit tick-source select can be changed only by a write that carries the key while the watchdog is already running. The counter clears when the software service key arrives, when the selected prescaler issues its own clear strobe, or when the chip enters a standby mode (sleep, stop or watch). Standby entry does not clear the counter in hardware mode with standby operation enabled. Hardware mode is chosen at reset by a configuration pin and needs no software start. In that mode with standby operation enabled, the count keeps running through standby, so a missed service still ends in a reset.

Top module: `wdt_lock_top`

## Requirements
- R1: After reset, `wdtActive`, `selCode`, `count`, `rstReq` and `rstFlag` are all zero.
- R2: A write (`wrEn`=1) with `wrCtrl`=4'b0101 sets `wdtActive` and clears `count` at the next clock edge. A write with any other control value does not start an idle watchdog.
- R3: Once `wdtActive` is 1, no write clears it. Only `rstN` low returns it to 0.
- R4: `selCode` takes `wrSel` only on a write with `wrCtrl`=4'b0101 while `wdtActive` is already 1. Any other write, including the write that starts the watchdog, leaves `selCode` unchanged.
- R5: Source decoding works as follows. If `selCode[0]`=1, the source is `subTick`/`subClr`. If `selCode` is 3'b100 or 3'b110, the source is `watchTick`/`watchClr`. If `selCode` is 3'b000 or 3'b010, the source is `mainTick`/`mainClr`. While active, each tick of the selected source raises `count` by one, and ticks from unselected sources have no effect.
- R6: While `mainStopped`=1, `mainTick` is ignored. The watch and sub sources still count.
- R7: While active, a clear strobe from the selected source sets `count` to 0 at the next edge. A clear strobe from an unselected source has no effect.
- R8: In a cycle where any of `sleepMode`, `stopMode` or `watchMode` is high and none of them was high in the previous cycle, `count` is set to 0. The exception is hardware mode with `standbyRunEn`=1.
- R9: If `hwModeCfg`=1 after reset, `wdtActive` becomes 1 at the first clock edge without any write. With `standbyRunEn`=1, the count then carries on through standby entry.
- R10: A selected tick while `count`=3 with no clear pending wraps `count` to 0 and pulses `rstReq` for exactly one cycle. It also sets `rstFlag`, which stays 1 until reset.
- R11: While `wdtActive`=0, ticks do not change `count`.
- R12: In a single cycle, a clear (key write, selected clear strobe or standby entry) takes priority over a tick, so no overflow can happen in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous system reset |
| wrEn | input | 1 | Register write strobe |
| wrCtrl | input | 4 | Control/key field of the write |
| wrSel | input | 3 | Tick-source select field of the write |
| hwModeCfg | input | 1 | Selects hardware mode (self-starting) |
| standbyRunEn | input | 1 | Keep counting through standby in hardware mode |
| mainStopped | input | 1 | Main clock halted, subclock-only operation |
| sleepMode | input | 1 | Chip is in sleep mode |
| stopMode | input | 1 | Chip is in stop mode |
| watchMode | input | 1 | Chip is in watch mode |
| mainTick | input | 1 | Tick from the main-clock timebase |
| watchTick | input | 1 | Tick from the watch prescaler |
| subTick | input | 1 | Tick from the sub-oscillator timer |
| mainClr | input | 1 | Clear strobe of the main timebase |
| watchClr | input | 1 | Clear strobe of the watch prescaler |
| subClr | input | 1 | Clear strobe of the sub-oscillator timer |
| wdtActive | output | 1 | Watchdog running |
| selCode | output | 3 | Current tick-source select |
| count | output | 2 | Watchdog counter value |
| rstReq | output | 1 | One-cycle reset request |
| rstFlag | output | 1 | Sticky record of a watchdog reset |

## Verification
The bench looks for the exact overflow cycle. A counter that is off by one would raise `rstReq` after three or five ticks instead of four, or would hold the pulse for two cycles. It checks a key write that both starts the watchdog and tries to change the select: a design that accepts the select on the starting write shows a wrong `selCode`. It also checks clear strobes and ticks from unselected sources, which a design with a loose source mux would let through. Standby entry is tested in hardware mode with standby running enabled and disabled, and with a held standby level, because a level-sensitive clear would freeze the count for the whole of standby. Random traffic mixes these cases with main-clock stops and non-key writes, so that stopping an active watchdog shows up at once.

// File: rtl/wdt_lock_pkg.sv
package wdt_lock_pkg;

  // Strobes handed from the control to the counter datapath
  typedef struct packed {
    logic clrCnt;
    logic tick;
  } wdtStrobe_t;

  typedef enum logic [1:0] {
    SRC_MAIN  = 2'd0,
    SRC_WATCH = 2'd1,
    SRC_SUB   = 2'd2
  } tickSrc_e;

  // Bit 0 set picks the sub-oscillator timer; otherwise bit 2 picks the watch prescaler
  function automatic tickSrc_e decodeSrc(input logic [2:0] sel);
    if (sel[0])      return SRC_SUB;
    else if (sel[2]) return SRC_WATCH;
    else             return SRC_MAIN;
  endfunction

endpackage

// File: rtl/wdt_lock_ctrl.sv
module wdt_lock_ctrl
  import wdt_lock_pkg::*;
#(
  parameter int CTRL_W = 4,
  parameter int SEL_W  = 3,
  parameter logic [CTRL_W-1:0] KEY = 4'b0101
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [CTRL_W-1:0] wrCtrl,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic              hwModeCfg,
  input  logic              standbyRunEn,
  input  logic              mainStopped,
  input  logic              sleepMode,
  input  logic              stopMode,
  input  logic              watchMode,
  input  logic              mainTick,
  input  logic              watchTick,
  input  logic              subTick,
  input  logic              mainClr,
  input  logic              watchClr,
  input  logic              subClr,
  output logic              activeQ,
  output logic [SEL_W-1:0]  selQ,
  output wdtStrobe_t        strobes
);

  logic hwModeQ;
  logic prevStandbyQ;
  logic keyWrite;
  logic standbyNow;
  logic standbyEntry;
  logic keepInStandby;
  logic srcTick;
  logic srcClr;
  tickSrc_e src;

  assign keyWrite      = wrEn && (wrCtrl == KEY);
  assign standbyNow    = sleepMode | stopMode | watchMode;
  assign standbyEntry  = standbyNow & ~prevStandbyQ;
  assign keepInStandby = hwModeQ & standbyRunEn;
  assign src           = decodeSrc(selQ[2:0]);

  always_comb begin
    unique case (src)
      SRC_SUB:   begin srcTick = subTick;   srcClr = subClr;   end
      SRC_WATCH: begin srcTick = watchTick; srcClr = watchClr; end
      default:   begin srcTick = mainTick & ~mainStopped; srcClr = mainClr; end
    endcase
  end

  always_comb begin
    strobes.tick   = activeQ & srcTick;
    strobes.clrCnt = keyWrite
                   | (activeQ & srcClr)
                   | (standbyEntry & ~keepInStandby);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ      <= 1'b0;
      hwModeQ      <= 1'b0;
      selQ         <= '0;
      prevStandbyQ <= 1'b0;
    end else begin
      activeQ      <= activeQ | keyWrite | hwModeCfg;
      hwModeQ      <= hwModeQ | hwModeCfg;
      prevStandbyQ <= standbyNow;
      if (keyWrite && activeQ) selQ <= wrSel;
    end
  end

  assert_active_sticky_R3 : assert property (@(posedge clk) disable iff (!rstN)
    activeQ |=> activeQ);

  assert_sel_guard_R4 : assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && wrCtrl == KEY && activeQ) |=> $stable(selQ));

  assert_idle_no_tick_R11 : assert property (@(posedge clk) disable iff (!rstN)
    !activeQ |-> !strobes.tick);

  assert_main_halted_R6 : assert property (@(posedge clk) disable iff (!rstN)
    (mainStopped && !selQ[0] && !selQ[2]) |-> !strobes.tick);

  assert_key_starts_R2 : assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrCtrl == KEY) |=> activeQ);

endmodule

// File: rtl/wdt_lock_datapath.sv
module wdt_lock_datapath
  import wdt_lock_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdtStrobe_t       strobes,
  output logic [CNT_W-1:0] countQ,
  output logic             rstReqQ,
  output logic             rstFlagQ
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ   <= '0;
      rstReqQ  <= 1'b0;
      rstFlagQ <= 1'b0;
    end else begin
      rstReqQ <= 1'b0;
      if (strobes.clrCnt) begin
        countQ <= '0;
      end else if (strobes.tick) begin
        if (countQ == CNT_MAX) begin
          countQ   <= '0;
          rstReqQ  <= 1'b1;
          rstFlagQ <= 1'b1;
        end else begin
          countQ <= countQ + 1'b1;
        end
      end
    end
  end

  assert_pulse_single_R10 : assert property (@(posedge clk) disable iff (!rstN)
    rstReqQ |=> !rstReqQ);

  assert_flag_sticky_R10 : assert property (@(posedge clk) disable iff (!rstN)
    rstFlagQ |=> rstFlagQ);

  assert_clear_wins_R12 : assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrCnt |=> (countQ == '0 && !rstReqQ));

  assert_req_sets_flag_R10 : assert property (@(posedge clk) disable iff (!rstN)
    rstReqQ |-> rstFlagQ);

endmodule

// File: rtl/wdt_lock_top.sv
module wdt_lock_top
  import wdt_lock_pkg::*;
#(
  parameter int CTRL_W = 4,
  parameter int SEL_W  = 3,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [CTRL_W-1:0] wrCtrl,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic              hwModeCfg,
  input  logic              standbyRunEn,
  input  logic              mainStopped,
  input  logic              sleepMode,
  input  logic              stopMode,
  input  logic              watchMode,
  input  logic              mainTick,
  input  logic              watchTick,
  input  logic              subTick,
  input  logic              mainClr,
  input  logic              watchClr,
  input  logic              subClr,
  output logic              wdtActive,
  output logic [SEL_W-1:0]  selCode,
  output logic [CNT_W-1:0]  count,
  output logic              rstReq,
  output logic              rstFlag
);

  wdtStrobe_t strobes;

  wdt_lock_ctrl #(
    .CTRL_W(CTRL_W),
    .SEL_W (SEL_W),
    .KEY   (CTRL_W'(4'b0101))
  ) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .wrEn        (wrEn),
    .wrCtrl      (wrCtrl),
    .wrSel       (wrSel),
    .hwModeCfg   (hwModeCfg),
    .standbyRunEn(standbyRunEn),
    .mainStopped (mainStopped),
    .sleepMode   (sleepMode),
    .stopMode    (stopMode),
    .watchMode   (watchMode),
    .mainTick    (mainTick),
    .watchTick   (watchTick),
    .subTick     (subTick),
    .mainClr     (mainClr),
    .watchClr    (watchClr),
    .subClr      (subClr),
    .activeQ     (wdtActive),
    .selQ        (selCode),
    .strobes     (strobes)
  );

  wdt_lock_datapath #(
    .CNT_W(CNT_W)
  ) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .countQ  (count),
    .rstReqQ (rstReq),
    .rstFlagQ(rstFlag)
  );

endmodule

// File: tb/wdt_lock_top_test.sv
`timescale 1ns/1ps
module wdt_lock_top_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 0, hwModeCfg = 0, standbyRunEn = 0, mainStopped = 0;
  logic sleepMode = 0, stopMode = 0, watchMode = 0;
  logic mainTick = 0, watchTick = 0, subTick = 0;
  logic mainClr = 0, watchClr = 0, subClr = 0;
  logic [3:0] wrCtrl = 0;
  logic [2:0] wrSel = 0;
  logic wdtActive, rstReq, rstFlag;
  logic [2:0] selCode;
  logic [1:0] count;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // bench-side model state
  logic mActive, mHw, mPrevSb, mFlag, mReq;
  logic [2:0] mSel;
  logic [1:0] mCnt;

  always #4 clk = ~clk;

  wdt_lock_top uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrCtrl(wrCtrl), .wrSel(wrSel),
    .hwModeCfg(hwModeCfg), .standbyRunEn(standbyRunEn), .mainStopped(mainStopped),
    .sleepMode(sleepMode), .stopMode(stopMode), .watchMode(watchMode),
    .mainTick(mainTick), .watchTick(watchTick), .subTick(subTick),
    .mainClr(mainClr), .watchClr(watchClr), .subClr(subClr),
    .wdtActive(wdtActive), .selCode(selCode), .count(count),
    .rstReq(rstReq), .rstFlag(rstFlag)
  );

  function automatic logic pickTick(input logic [2:0] s);
    if (s[0]) return subTick;
    if (s[2]) return watchTick;
    return mainTick & ~mainStopped;
  endfunction

  function automatic logic pickClr(input logic [2:0] s);
    if (s[0]) return subClr;
    if (s[2]) return watchClr;
    return mainClr;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compareAll(input string tag);
    chk(tag, "wdtActive", wdtActive, mActive);
    chk(tag, "selCode", selCode, mSel);
    chk(tag, "count", count, mCnt);
    chk(tag, "rstReq", rstReq, mReq);
    chk(tag, "rstFlag", rstFlag, mFlag);
  endtask

  // Predict from the inputs now present, clock once, compare, drop pulses
  task automatic step(input string tag);
    logic sb, entry, key, tk, clr;
    sb    = sleepMode | stopMode | watchMode;
    entry = sb & ~mPrevSb;
    key   = wrEn && (wrCtrl == 4'b0101);
    tk    = mActive & pickTick(mSel);
    clr   = key | (mActive & pickClr(mSel)) | (entry & ~(mHw & standbyRunEn));
    mReq  = 1'b0;
    if (key && mActive) mSel = wrSel;
    if (clr) mCnt = 2'd0;
    else if (tk) begin
      if (mCnt == 2'd3) begin mCnt = 2'd0; mReq = 1'b1; mFlag = 1'b1; end
      else mCnt = mCnt + 2'd1;
    end
    mActive = mActive | key | hwModeCfg;
    mHw     = mHw | hwModeCfg;
    mPrevSb = sb;
    @(posedge clk);
    #1;
    compareAll(tag);
    wrEn = 0; mainTick = 0; watchTick = 0; subTick = 0;
    mainClr = 0; watchClr = 0; subClr = 0;
  endtask

  task automatic doReset(input logic cfg);
    rstN = 1'b0;
    hwModeCfg = cfg;
    wrEn = 0; mainTick = 0; watchTick = 0; subTick = 0;
    mainClr = 0; watchClr = 0; subClr = 0;
    sleepMode = 0; stopMode = 0; watchMode = 0; mainStopped = 0;
    @(posedge clk); @(posedge clk); #1;
    mActive = 0; mHw = 0; mPrevSb = 0; mFlag = 0; mReq = 0; mSel = 0; mCnt = 0;
    compareAll("R1");
    rstN = 1'b1;
  endtask

  task automatic keyWr(input logic [2:0] s, input string tag);
    wrEn = 1; wrCtrl = 4'b0101; wrSel = s;
    step(tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int seed;
    seed = 12345;
    void'($urandom(seed));
    doReset(1'b0);

    // R11: ticks while idle do nothing
    mainTick = 1; step("R11");
    // R2: non-key write does not start
    wrEn = 1; wrCtrl = 4'b1010; wrSel = 3'b001; step("R2");
    // R4: starting write must not load the select
    keyWr(3'b001, "R4");
    chk("R2", "started", wdtActive, 1);
    // R5: main source counts, others ignored
    mainTick = 1; step("R5");
    watchTick = 1; subTick = 1; step("R5");
    // R7: unselected clear ignored, selected clear works
    watchClr = 1; step("R7");
    mainClr = 1; step("R7");
    // R3: writes cannot stop it
    wrEn = 1; wrCtrl = 4'b0000; wrSel = 3'b111; step("R3");
    // R4: key write while active loads select 3'b100 (watch)
    keyWr(3'b100, "R4");
    // R6: main clock stop does not block watch source
    mainStopped = 1;
    for (int i = 0; i < 3; i++) begin watchTick = 1; step("R6"); end
    chk("R6", "count3", count, 3);
    // R12: clear beats tick at terminal count
    watchTick = 1; watchClr = 1; step("R12");
    // R10: four ticks after clear give the pulse
    for (int i = 0; i < 4; i++) begin watchTick = 1; step("R10"); end
    chk("R10", "pulse", rstReq, 1);
    step("R10");
    chk("R10", "flag", rstFlag, 1);
    // R6: main source halted
    keyWr(3'b010, "R4");
    mainTick = 1; step("R6");
    chk("R6", "halted", count, 0);
    mainStopped = 0;
    mainTick = 1; step("R5");
    // R8: standby entry clears in software mode, held level does not
    mainTick = 1; step("R5");
    sleepMode = 1; step("R8");
    mainTick = 1; step("R8");
    mainTick = 1; step("R8");
    chk("R8", "held", count, 2);
    sleepMode = 0; step("R8");
    stopMode = 1; standbyRunEn = 1; step("R8");
    stopMode = 0;

    // R9: hardware mode self-starts and runs through standby
    doReset(1'b1);
    step("R9");
    chk("R9", "selfstart", wdtActive, 1);
    standbyRunEn = 1;
    mainTick = 1; step("R9");
    mainTick = 1; step("R9");
    watchMode = 1; step("R9");
    chk("R9", "kept", count, 2);
    mainTick = 1; step("R9");
    mainTick = 1; step("R10");
    chk("R10", "hwpulse", rstReq, 1);
    watchMode = 0; standbyRunEn = 0;
    watchMode = 1; step("R8");
    watchMode = 0;
    hwModeCfg = 0;

    // random mix
    doReset(1'b0);
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 4) begin
        wrEn = 1; wrCtrl = ($urandom_range(0, 1) != 0) ? 4'b0101 : 4'($urandom);
        wrSel = 3'($urandom);
      end
      mainTick  = ($urandom_range(0, 2) == 0);
      watchTick = ($urandom_range(0, 2) == 0);
      subTick   = ($urandom_range(0, 2) == 0);
      mainClr   = ($urandom_range(0, 30) == 0);
      watchClr  = ($urandom_range(0, 30) == 0);
      subClr    = ($urandom_range(0, 30) == 0);
      if ($urandom_range(0, 20) == 0) mainStopped = ~mainStopped;
      if ($urandom_range(0, 40) == 0) sleepMode = ~sleepMode;
      if ($urandom_range(0, 60) == 0) stopMode = ~stopMode;
      if ($urandom_range(0, 60) == 0) watchMode = ~watchMode;
      if ($urandom_range(0, 80) == 0) standbyRunEn = ~standbyRunEn;
      step("R5");
      if (i == 2000) doReset($urandom_range(0, 1) != 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule